// File: doc/BRIEF.md
# Sync-Locked Decimating Pixel Sampler

This block takes a reduced-resolution snapshot of an RGB video stream that outside converters have already digitised. It follows the vertical and horizontal sync lines. A frame opens on the trailing edge of a vsync pulse, and the lines within it are counted in groups of eight. Only the first line of each group is captured. On that line, 96 words of 24 bits are taken from the converter bus and written into an internal line buffer.

Sample times are not taken from a free loop. Each one is an absolute deadline on a running timestamp. The first deadline is set a programmable delay after the hsync trailing edge. Each later deadline is the previous one plus a programmable period, so the spacing between samples has no jitter and builds up no error. The converter output-enable is asserted only while a line is being captured. A one-clock ready pulse marks a complete line, and downstream logic then reads the buffer through an asynchronous read port. A new line reference that arrives during a capture aborts that capture and raises a sticky overrun flag.

Top module: `vsamp_top`

## Requirements
- R1: A frame starts on a high-to-low change of vsync that follows a low-to-high change of vsync. Hsync pulses seen before the first frame start cause no capture and never assert adc_oe_n low. A new frame start restarts the line and group counting.
- R2: The line reference is the falling edge of hsync, recognised only after a rising edge. Let k be the first clock edge at which hsync is sampled low. The two-flop synchroniser then recognises the reference at edge k+2.
- R3: Sample 0 is taken at edge k+D, where D is the effective start delay. D equals start_delay, or 80 when start_delay is 0. D must be at least 3.
- R4: Sample i is taken at edge k+D+i*P, where P is the effective period. P equals pixel_period, or 21 when pixel_period is 0. The deadlines are absolute, so the spacing never drifts.
- R5: Exactly 96 samples are stored at buffer indices 0 to 95. Each sample is the 24-bit value of adc_data: red on bits 7:0, green on 15:8 and blue on 23:16. rd_data shows the entry selected by rd_addr, and reads 0 for any address above 95.
- R6: Within a frame, only lines whose position in their group of eight is 0 are captured. Only the first group_count groups are captured. With group_count equal to 0, no line is captured and the buffer keeps its contents.
- R7: adc_oe_n is low from the edge that recognises the reference of a captured line until the edge of its 96th sample. That is exactly D-2+95*P clock periods.
- R8: line_ready is high for exactly one clock, in the cycle after the 96th sample is written.
- R9: A line reference that arrives while a capture is in progress aborts the capture, so no line_ready pulse follows, and sets overrun. overrun stays set until the next frame start.
- R10: After reset, adc_oe_n is 1, line_ready is 0, overrun is 0 and every buffer entry reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_data | input | 24 | Digitised RGB word from the converters |
| hsync | input | 1 | Horizontal sync, asynchronous |
| vsync | input | 1 | Vertical sync, asynchronous |
| start_delay | input | 16 | Clocks from the hsync trailing edge to the first sample; 0 selects 80 |
| pixel_period | input | 16 | Clocks between samples; 0 selects 21 |
| group_count | input | 8 | Number of eight-line groups captured per frame |
| adc_oe_n | output | 1 | Converter output enable, active low |
| rd_addr | input | 7 | Line buffer read address |
| rd_data | output | 24 | Line buffer entry at rd_addr |
| line_ready | output | 1 | One-clock pulse when a full line is stored |
| overrun | output | 1 | Sticky flag for an aborted capture |

## Verification
The hardest case to reach from the ports is the cycle placement of every sample relative to the hsync trailing edge. The capture only shows which bus value was latched, not when it was latched. The stimulus therefore drives adc_data with the running clock count, so each word read back from the buffer is a timestamp of its own sampling edge. Overrun needs a line period shorter than the capture window, and the stimulus sets this up on purpose. Group skipping needs whole frames of many lines, which the vector walk provides with short periods so that the frames stay small.

// File: rtl/vsamp_pkg.sv
`timescale 1ns/1ps
package vsamp_pkg;
  // clocks between the first edge that samples a sync pin and the edge that acts on it
  localparam int SYNC_LAT = 2;
endpackage

// File: rtl/vsamp_edge.sv
`timescale 1ns/1ps
module vsamp_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic fall_evt
);
  logic s1, s2, s3, armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0; s2 <= 1'b0; s3 <= 1'b0; armed <= 1'b0;
    end else begin
      s1 <= din;
      s2 <= s1;
      s3 <= s2;
      if (s2 && !s3)    armed <= 1'b1;
      else if (fall_evt) armed <= 1'b0;
    end
  end

  assign fall_evt = armed && s3 && !s2;

  // R2: one trailing edge gives one event
  p_fall_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |=> !fall_evt);
endmodule

// File: rtl/vsamp_line_seq.sv
`timescale 1ns/1ps
module vsamp_line_seq #(
  parameter int GROUP_LINES = 8,
  parameter int GRP_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_evt,
  input  logic             line_evt,
  input  logic [GRP_W-1:0] group_count,
  output logic             line_start
);
  localparam int POS_W = $clog2(GROUP_LINES);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(GROUP_LINES - 1);

  logic             active;
  logic [POS_W-1:0] line_pos;
  logic [GRP_W-1:0] grp;

  assign line_start = line_evt && active && !frame_evt &&
                      (line_pos == '0) && (grp < group_count);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; line_pos <= '0; grp <= '0;
    end else if (frame_evt) begin
      active <= 1'b1; line_pos <= '0; grp <= '0;
    end else if (line_evt && active) begin
      if (line_pos == LAST_POS) begin
        line_pos <= '0;
        grp      <= grp + 1'b1;
        if (grp + 1'b1 >= group_count) active <= 1'b0;
      end else begin
        line_pos <= line_pos + 1'b1;
      end
    end
  end

  // R6: a capture opens a group, so the next line is not a group head
  p_start_head_r6: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> (line_pos == POS_W'(1)));
endmodule

// File: rtl/vsamp_capture.sv
`timescale 1ns/1ps
module vsamp_capture
  import vsamp_pkg::*;
#(
  parameter int DATA_W      = 24,
  parameter int NUM_SAMPLES = 96,
  parameter int TS_W        = 16,
  parameter int DEF_START   = 80,
  parameter int DEF_PERIOD  = 21,
  localparam int IDX_W      = $clog2(NUM_SAMPLES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              line_evt,
  input  logic              frame_evt,
  input  logic [DATA_W-1:0] adc_data,
  input  logic [TS_W-1:0]   start_delay,
  input  logic [TS_W-1:0]   pixel_period,
  output logic              adc_oe_n,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [DATA_W-1:0] wr_data,
  output logic              line_ready,
  output logic              overrun
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SAMPLES - 1);

  function automatic logic [TS_W-1:0] eff_delay(input logic [TS_W-1:0] d);
    return (d == '0) ? TS_W'(DEF_START) : d;
  endfunction

  function automatic logic [TS_W-1:0] eff_period(input logic [TS_W-1:0] p);
    return (p == '0) ? TS_W'(DEF_PERIOD) : p;
  endfunction

  // clocks from the edge that acts on the sync to the first sample edge
  function automatic logic [TS_W-1:0] lead_time(input logic [TS_W-1:0] d);
    logic [TS_W-1:0] e;
    e = eff_delay(d);
    return (e > TS_W'(SYNC_LAT)) ? e - TS_W'(SYNC_LAT) : TS_W'(1);
  endfunction

  logic [TS_W-1:0]  tnow, deadline;
  logic [IDX_W-1:0] idx;
  logic             busy, hit;

  assign hit      = busy && (tnow == deadline) && !line_evt;
  assign wr_en    = hit;
  assign wr_idx   = idx;
  assign wr_data  = adc_data;
  assign adc_oe_n = !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tnow <= '0; deadline <= '0; idx <= '0;
      busy <= 1'b0; line_ready <= 1'b0; overrun <= 1'b0;
    end else begin
      tnow       <= tnow + 1'b1;
      line_ready <= 1'b0;
      if (frame_evt) overrun <= 1'b0;
      if (line_evt) begin
        if (busy) overrun <= 1'b1;
        busy <= start;
        if (start) begin
          idx      <= '0;
          deadline <= tnow + lead_time(start_delay);
        end
      end else if (hit) begin
        if (idx == LAST_IDX) begin
          busy       <= 1'b0;
          line_ready <= 1'b1;
        end else begin
          idx      <= idx + 1'b1;
          deadline <= deadline + eff_period(pixel_period);
        end
      end
    end
  end

  // checker state: clocks since the last buffer write
  logic [TS_W-1:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     gap_q <= '0;
    else if (wr_en) gap_q <= TS_W'(1);
    else            gap_q <= gap_q + 1'b1;
  end

  // R4: samples inside a line sit exactly one period apart
  p_sample_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx != '0) |-> (gap_q == eff_period(pixel_period)));

  // R7: the enable is released right after the last sample
  p_oe_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == LAST_IDX) |=> adc_oe_n);

  // R8: ready follows the last sample write
  p_ready_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    line_ready |-> $past(wr_en && wr_idx == LAST_IDX));

  // R9: overrun rises only when a reference hits a running capture
  p_overrun_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(line_evt && busy));
endmodule

// File: rtl/vsamp_top.sv
`timescale 1ns/1ps
module vsamp_top #(
  parameter int DATA_W      = 24,
  parameter int NUM_SAMPLES = 96,
  parameter int TS_W        = 16,
  parameter int GRP_W       = 8,
  parameter int GROUP_LINES = 8,
  parameter int DEF_START   = 80,
  parameter int DEF_PERIOD  = 21
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [DATA_W-1:0]              adc_data,
  input  logic                           hsync,
  input  logic                           vsync,
  input  logic [TS_W-1:0]                start_delay,
  input  logic [TS_W-1:0]                pixel_period,
  input  logic [GRP_W-1:0]               group_count,
  output logic                           adc_oe_n,
  input  logic [$clog2(NUM_SAMPLES)-1:0] rd_addr,
  output logic [DATA_W-1:0]              rd_data,
  output logic                           line_ready,
  output logic                           overrun
);
  localparam int IDX_W = $clog2(NUM_SAMPLES);

  logic              hs_fall, vs_fall, line_start, wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] mem [NUM_SAMPLES];

  vsamp_edge u_hs (.clk(clk), .rst_n(rst_n), .din(hsync), .fall_evt(hs_fall));
  vsamp_edge u_vs (.clk(clk), .rst_n(rst_n), .din(vsync), .fall_evt(vs_fall));

  vsamp_line_seq #(.GROUP_LINES(GROUP_LINES), .GRP_W(GRP_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .frame_evt(vs_fall), .line_evt(hs_fall),
    .group_count(group_count), .line_start(line_start));

  vsamp_capture #(.DATA_W(DATA_W), .NUM_SAMPLES(NUM_SAMPLES), .TS_W(TS_W),
                  .DEF_START(DEF_START), .DEF_PERIOD(DEF_PERIOD)) u_cap (
    .clk(clk), .rst_n(rst_n), .start(line_start), .line_evt(hs_fall),
    .frame_evt(vs_fall), .adc_data(adc_data), .start_delay(start_delay),
    .pixel_period(pixel_period), .adc_oe_n(adc_oe_n), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_data(wr_data), .line_ready(line_ready),
    .overrun(overrun));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SAMPLES; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
  end

  assign rd_data = (rd_addr < IDX_W'(NUM_SAMPLES)) ? mem[rd_addr] : '0;

  // R5: no write lands outside the buffer
  p_write_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_idx < IDX_W'(NUM_SAMPLES)));
endmodule

// File: tb/tb_vsamp_top.sv
`timescale 1ns/1ps
module tb_vsamp_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] adc_data = '0;
  logic        hsync = 1'b0, vsync = 1'b0;
  logic [15:0] start_delay = '0, pixel_period = '0;
  logic [7:0]  group_count = '0;
  logic [6:0]  rd_addr = '0;
  logic        adc_oe_n, line_ready, overrun;
  logic [23:0] rd_data;

  vsamp_top dut (.clk(clk), .rst_n(rst_n), .adc_data(adc_data), .hsync(hsync),
    .vsync(vsync), .start_delay(start_delay), .pixel_period(pixel_period),
    .group_count(group_count), .adc_oe_n(adc_oe_n), .rd_addr(rd_addr),
    .rd_data(rd_data), .line_ready(line_ready), .overrun(overrun));

  always #4 clk = ~clk;

  int unsigned cyc = 0, ready_cnt = 0, oe_cnt = 0, last_ready = 0;
  int checks = 0, fails = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    adc_data = cyc[23:0];
    if (line_ready) begin ready_cnt++; last_ready = cyc; end
    if (!adc_oe_n) oe_cnt++;
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic frame_start();
    @(negedge clk); vsync = 1'b1; idle(4); vsync = 1'b0; idle(6);
  endtask

  task automatic hline(input int len, output int unsigned h);
    @(negedge clk); hsync = 1'b1; idle(4); hsync = 1'b0; h = cyc; idle(len - 5);
  endtask

  task automatic rd(input int a, output logic [23:0] v);
    @(negedge clk); rd_addr = 7'(a); #1 v = rd_data;
  endtask

  typedef struct packed {
    logic [15:0] dly; logic [15:0] per; logic [7:0] grp;
    logic [15:0] lines; logic [15:0] llen;
  } vec_t;
  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{16'd80,  16'd21, 8'd1, 16'd9,  16'd2300},
    '{16'd0,   16'd0,  8'd1, 16'd8,  16'd2300},
    '{16'd3,   16'd1,  8'd2, 16'd16, 16'd200},
    '{16'd10,  16'd4,  8'd3, 16'd20, 16'd500},
    '{16'd200, 16'd7,  8'd2, 16'd24, 16'd1000},
    '{16'd5,   16'd2,  8'd0, 16'd9,  16'd300}
  };

  initial begin
    #1600000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [23:0] v, prev0;
    int unsigned h, hlast, r0, o0, ed, ep, nexp, lenw;
    idle(3);
    // R10 reset state
    check(adc_oe_n == 1'b1, "R10 oe_n", adc_oe_n, 1);
    check(line_ready == 1'b0, "R10 line_ready", line_ready, 0);
    check(overrun == 1'b0, "R10 overrun", overrun, 0);
    rd(5, v); check(v == 24'd0, "R10 buffer", v, 0);
    @(negedge clk); rst_n = 1'b1; idle(4);

    // R1: hsync before any frame start captures nothing
    start_delay = 16'd5; pixel_period = 16'd1; group_count = 8'd4;
    r0 = ready_cnt; o0 = oe_cnt;
    for (int l = 0; l < 3; l++) hline(200, h);
    check(ready_cnt == r0, "R1 no capture before frame", ready_cnt - r0, 0);
    check(oe_cnt == o0, "R1 oe idle before frame", oe_cnt - o0, 0);

    prev0 = '0;
    for (int n = 0; n < NV; n++) begin
      start_delay = VECS[n].dly; pixel_period = VECS[n].per;
      group_count = VECS[n].grp;
      ed = (VECS[n].dly == 0) ? 80 : VECS[n].dly;
      ep = (VECS[n].per == 0) ? 21 : VECS[n].per;
      frame_start();
      r0 = ready_cnt; o0 = oe_cnt; nexp = 0; hlast = 0;
      for (int l = 0; l < VECS[n].lines; l++) begin
        hline(VECS[n].llen, h);
        if ((l % 8) == 0 && (l / 8) < VECS[n].grp) begin nexp++; hlast = h; end
      end
      check(ready_cnt - r0 == nexp, $sformatf("R6 ready count v%0d", n), ready_cnt - r0, nexp);
      check(oe_cnt - o0 == nexp * (ed - 2 + 95 * ep), $sformatf("R7 oe window v%0d", n),
            oe_cnt - o0, nexp * (ed - 2 + 95 * ep));
      check(overrun == 1'b0, $sformatf("R9 no overrun v%0d", n), overrun, 0);
      if (nexp > 0) begin
        rd(0, v);
        check(v == 24'(hlast + ed), $sformatf("R3 first sample v%0d", n), v, 24'(hlast + ed));
        prev0 = v;
        rd(1, v);
        check(v == 24'(hlast + ed + ep), $sformatf("R4 sample1 v%0d", n), v, 24'(hlast + ed + ep));
        rd(47, v);
        check(v == 24'(hlast + ed + 47 * ep), $sformatf("R4 sample47 v%0d", n), v, 24'(hlast + ed + 47 * ep));
        rd(95, v);
        check(v == 24'(hlast + ed + 95 * ep), $sformatf("R5 sample95 v%0d", n), v, 24'(hlast + ed + 95 * ep));
        check(v[7:0] == 8'(hlast + ed + 95 * ep), $sformatf("R5 red field v%0d", n), v[7:0], 8'(hlast + ed + 95 * ep));
        check(last_ready == hlast + 1 + ed + 95 * ep, $sformatf("R8 ready cycle v%0d", n),
              last_ready, hlast + 1 + ed + 95 * ep);
      end else begin
        rd(0, v);
        check(v == prev0, $sformatf("R6 buffer kept v%0d", n), v, prev0);
      end
    end

    // R5 out of range reads
    rd(96, v);  check(v == 24'd0, "R5 addr 96", v, 0);
    rd(127, v); check(v == 24'd0, "R5 addr 127", v, 0);

    // R9 overrun: line shorter than the capture window
    start_delay = 16'd80; pixel_period = 16'd21; group_count = 8'd1;
    frame_start();
    r0 = ready_cnt;
    for (int l = 0; l < 8; l++) begin
      lenw = (l == 0) ? 1000 : 300;
      hline(lenw, h);
    end
    idle(2200);
    check(ready_cnt == r0, "R9 aborted line no ready", ready_cnt - r0, 0);
    check(overrun == 1'b1, "R9 overrun set", overrun, 1);
    frame_start();
    check(overrun == 1'b0, "R9 overrun cleared by frame", overrun, 0);

    // R1 frame restart: restart mid-group begins a new group head
    start_delay = 16'd5; pixel_period = 16'd1; group_count = 8'd1;
    frame_start();
    for (int l = 0; l < 3; l++) hline(200, h);
    r0 = ready_cnt;
    frame_start();
    hline(200, h);
    check(ready_cnt - r0 == 1, "R1 restart captures head", ready_cnt - r0, 1);
    rd(0, v); check(v == 24'(h + 5), "R2 latency after restart", v, 24'(h + 5));

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule